// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the hardwired state machine that runs a small 16-bit load/store processor with eight registers. It steps each instruction through a PC-read state, an instruction-read state and one or two execute states, and it drives every control strobe of the datapath. These strobes are PC read and PC write, PC source select, instruction read, data-memory read and write, register write, register write-back source, ALU operand source, ALU operation and flag-register write. The controller sees only two things: the 4-bit opcode of the instruction register, taken from instruction bits [15:12], and a branch-taken signal. The datapath raises branch-taken when the stored zero and carry flags satisfy the condition of the current conditional jump.

The number of states differs per instruction. Register-register ALU, register-immediate ALU and load instructions take four states. Store, compare, jump and unknown opcodes take three. Every instruction ends in a state that writes the PC exactly once: PC+1 for sequential flow, or the PC-relative target for a jump that is taken. The next state after that is always the PC-read state. While the synchronous active-high reset is high, every strobe is held low, and the state after reset is the PC-read state.

States: `ST_PC_RD`, `ST_IFETCH`, `ST_EX_RR`, `ST_EX_RI`, `ST_ALU_WB`, `ST_LD_MEM`, `ST_LD_WB`, `ST_ST_MEM`, `ST_CMP_EX`, `ST_JMP_EX`, `ST_SKIP`. Transitions:
- `ST_PC_RD`→`ST_IFETCH`.
- `ST_IFETCH` dispatches on the opcode to `ST_EX_RR`, `ST_EX_RI`, `ST_LD_MEM`, `ST_ST_MEM`, `ST_CMP_EX`, `ST_JMP_EX` or `ST_SKIP`.
- `ST_EX_RR`/`ST_EX_RI`→`ST_ALU_WB`.
- `ST_LD_MEM`→`ST_LD_WB`.
- `ST_ALU_WB`, `ST_LD_WB`, `ST_ST_MEM`, `ST_CMP_EX`, `ST_JMP_EX` and `ST_SKIP` each go to `ST_PC_RD`.
- Reset from any state goes to `ST_PC_RD`.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst` is high, every output strobe is 0, whatever the current state. In the cycle after `rst` falls, the controller is in the PC-read state.
- R2: Every instruction starts with one cycle where only `pc_rd` is 1, followed by one cycle where only `ir_rd` is 1.
- R3: ADD (opcode 0) and AND (opcode 1) execute for one cycle with `alu_src`=0 and `alu_op` = 00 for ADD or 01 for AND, and no other strobe. The next cycle asserts `rf_wr` and `pc_wr`, with `wb_sel`=0 and `pc_sel`=0. `br_taken` has no effect.
- R4: ADDI (opcode 2) and ANDI (opcode 3) follow the same pattern as R3, but with `alu_src`=1 in the execute cycle.
- R5: LD (opcode 4) asserts only `dm_rd` in its third cycle. Its fourth cycle asserts `rf_wr`, `wb_sel`=1 and `pc_wr`, with `pc_sel`=0.
- R6: ST (opcode 5) asserts `dm_wr` together with `pc_wr` (`pc_sel`=0) in its third and final cycle. `dm_wr` is never asserted in any other state.
- R7: CMP (opcode 6) has a single execute cycle that asserts `flag_wr`, `alu_op`=11 (subtract), `alu_src`=0 and `pc_wr` with `pc_sel`=0. It never asserts `rf_wr`.
- R8: JUMP (opcode 7) asserts `pc_wr` with `pc_sel`=1 in its third cycle, whatever the value of `br_taken`.
- R9: JE, JA, JB, JBE and JAE (opcodes 8 to 12) assert `pc_wr` in their third cycle, with `pc_sel` equal to `br_taken`.
- R10: Opcodes 13 to 15 are undefined. Their third cycle asserts only `pc_wr`, with `pc_sel`=0.
- R11: Every instruction asserts `pc_wr` in exactly one cycle, its last. The cycle after that is a PC-read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Instruction register bits [15:12] |
| br_taken | input | 1 | Flag condition of the current conditional jump is satisfied |
| pc_rd | output | 1 | PC drives the instruction address |
| pc_wr | output | 1 | PC register load enable |
| pc_sel | output | 1 | PC source: 0 = PC+1, 1 = PC-relative target |
| ir_rd | output | 1 | Instruction memory read / instruction register load |
| dm_rd | output | 1 | Data memory read |
| dm_wr | output | 1 | Data memory write |
| rf_wr | output | 1 | Register file write enable |
| wb_sel | output | 1 | Write-back source: 0 = ALU result, 1 = data memory |
| alu_src | output | 1 | ALU second operand: 0 = register, 1 = immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 and, 10 or, 11 subtract |
| flag_wr | output | 1 | Zero/carry flag register write enable |

## Verification
If the state register is wrong, the wrong strobe appears at the ports in that same cycle, because every output comes combinationally from the current state. An instruction that is one state too long or too short moves the PC-read/instruction-read pair of the next instruction, so a complete per-cycle comparison catches the error within one instruction. A dispatch mistake in the instruction-read state shows up one cycle later: the wrong execute strobe appears, or `pc_wr` arrives early. A reset that fails to gate the outputs shows up at once as a nonzero strobe while `rst` is high.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 2;

    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_ADDI = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ANDI = 4'd3;
    localparam logic [OPC_W-1:0] OPC_LD   = 4'd4;
    localparam logic [OPC_W-1:0] OPC_ST   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_CMP  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_JUMP = 4'd7;
    localparam logic [OPC_W-1:0] OPC_JE   = 4'd8;
    localparam logic [OPC_W-1:0] OPC_JA   = 4'd9;
    localparam logic [OPC_W-1:0] OPC_JB   = 4'd10;
    localparam logic [OPC_W-1:0] OPC_JBE  = 4'd11;
    localparam logic [OPC_W-1:0] OPC_JAE  = 4'd12;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD = 2'b00,
        ALU_AND = 2'b01,
        ALU_OR  = 2'b10,
        ALU_SUB = 2'b11
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_ALU_RR,
        CL_ALU_RI,
        CL_LOAD,
        CL_STORE,
        CL_CMP,
        CL_JMP,
        CL_BRC,
        CL_NONE
    } iclass_e;

    typedef enum logic [3:0] {
        ST_PC_RD,
        ST_IFETCH,
        ST_EX_RR,
        ST_EX_RI,
        ST_ALU_WB,
        ST_LD_MEM,
        ST_LD_WB,
        ST_ST_MEM,
        ST_CMP_EX,
        ST_JMP_EX,
        ST_SKIP
    } state_e;

    typedef struct packed {
        iclass_e cls;
        alu_op_e op;
    } dec_t;

    typedef struct packed {
        logic               pc_rd;
        logic               pc_wr;
        logic               pc_sel;
        logic               ir_rd;
        logic               dm_rd;
        logic               dm_wr;
        logic               rf_wr;
        logic               wb_sel;
        logic               alu_src;
        logic [ALUOP_W-1:0] alu_op;
        logic               flag_wr;
    } ctrl_t;

endpackage

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    always_comb begin
        dec.cls = CL_NONE;
        dec.op  = ALU_ADD;
        unique case (opcode)
            OPC_ADD:  begin dec.cls = CL_ALU_RR; dec.op = ALU_ADD; end
            OPC_AND:  begin dec.cls = CL_ALU_RR; dec.op = ALU_AND; end
            OPC_ADDI: begin dec.cls = CL_ALU_RI; dec.op = ALU_ADD; end
            OPC_ANDI: begin dec.cls = CL_ALU_RI; dec.op = ALU_AND; end
            OPC_LD:   dec.cls = CL_LOAD;
            OPC_ST:   dec.cls = CL_STORE;
            OPC_CMP:  begin dec.cls = CL_CMP; dec.op = ALU_SUB; end
            OPC_JUMP: dec.cls = CL_JMP;
            OPC_JE, OPC_JA, OPC_JB, OPC_JBE, OPC_JAE:
                      dec.cls = CL_BRC;
            default:  dec.cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
(
    input  state_e  state,
    input  iclass_e cls,
    output state_e  nxt
);

    always_comb begin
        nxt = ST_PC_RD;
        unique case (state)
            ST_PC_RD:  nxt = ST_IFETCH;
            ST_IFETCH: begin
                unique case (cls)
                    CL_ALU_RR: nxt = ST_EX_RR;
                    CL_ALU_RI: nxt = ST_EX_RI;
                    CL_LOAD:   nxt = ST_LD_MEM;
                    CL_STORE:  nxt = ST_ST_MEM;
                    CL_CMP:    nxt = ST_CMP_EX;
                    CL_JMP,
                    CL_BRC:    nxt = ST_JMP_EX;
                    default:   nxt = ST_SKIP;
                endcase
            end
            ST_EX_RR,
            ST_EX_RI:  nxt = ST_ALU_WB;
            ST_LD_MEM: nxt = ST_LD_WB;
            ST_ALU_WB,
            ST_LD_WB,
            ST_ST_MEM,
            ST_CMP_EX,
            ST_JMP_EX,
            ST_SKIP:   nxt = ST_PC_RD;
            default:   nxt = ST_PC_RD;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_drive.sv
module mc_ctrl_drive
    import mc_ctrl_pkg::*;
(
    input  logic   rst,
    input  state_e state,
    input  dec_t   dec,
    input  logic   br_taken,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = '0;
        if (!rst) begin
            unique case (state)
                ST_PC_RD:  ctl.pc_rd = 1'b1;
                ST_IFETCH: ctl.ir_rd = 1'b1;
                ST_EX_RR: begin
                    ctl.alu_op  = dec.op;
                    ctl.alu_src = 1'b0;
                end
                ST_EX_RI: begin
                    ctl.alu_op  = dec.op;
                    ctl.alu_src = 1'b1;
                end
                ST_ALU_WB: begin
                    ctl.rf_wr  = 1'b1;
                    ctl.wb_sel = 1'b0;
                    ctl.pc_wr  = 1'b1;
                end
                ST_LD_MEM: ctl.dm_rd = 1'b1;
                ST_LD_WB: begin
                    ctl.rf_wr  = 1'b1;
                    ctl.wb_sel = 1'b1;
                    ctl.pc_wr  = 1'b1;
                end
                ST_ST_MEM: begin
                    ctl.dm_wr = 1'b1;
                    ctl.pc_wr = 1'b1;
                end
                ST_CMP_EX: begin
                    ctl.alu_op  = dec.op;
                    ctl.flag_wr = 1'b1;
                    ctl.pc_wr   = 1'b1;
                end
                ST_JMP_EX: begin
                    ctl.pc_wr  = 1'b1;
                    ctl.pc_sel = (dec.cls == CL_JMP) || br_taken;
                end
                ST_SKIP:   ctl.pc_wr = 1'b1;
                default:   ctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               br_taken,
    output logic               pc_rd,
    output logic               pc_wr,
    output logic               pc_sel,
    output logic               ir_rd,
    output logic               dm_rd,
    output logic               dm_wr,
    output logic               rf_wr,
    output logic               wb_sel,
    output logic               alu_src,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               flag_wr
);

    state_e state;
    state_e nxt;
    dec_t   dec;
    ctrl_t  ctl;

    mc_ctrl_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    mc_ctrl_next u_next (
        .state (state),
        .cls   (dec.cls),
        .nxt   (nxt)
    );

    mc_ctrl_drive u_drive (
        .rst      (rst),
        .state    (state),
        .dec      (dec),
        .br_taken (br_taken),
        .ctl      (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PC_RD;
        else     state <= nxt;
    end

    assign pc_rd   = ctl.pc_rd;
    assign pc_wr   = ctl.pc_wr;
    assign pc_sel  = ctl.pc_sel;
    assign ir_rd   = ctl.ir_rd;
    assign dm_rd   = ctl.dm_rd;
    assign dm_wr   = ctl.dm_wr;
    assign rf_wr   = ctl.rf_wr;
    assign wb_sel  = ctl.wb_sel;
    assign alu_src = ctl.alu_src;
    assign alu_op  = ctl.alu_op;
    assign flag_wr = ctl.flag_wr;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
    import mc_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pc_rd,
    input logic               pc_wr,
    input logic               pc_sel,
    input logic               ir_rd,
    input logic               dm_rd,
    input logic               dm_wr,
    input logic               rf_wr,
    input logic               wb_sel,
    input logic               alu_src,
    input logic [ALUOP_W-1:0] alu_op,
    input logic               flag_wr
);

    always @(posedge clk) begin
        if (rst) begin
            p_rst_quiet_r1: assert ({pc_rd, pc_wr, pc_sel, ir_rd, dm_rd, dm_wr,
                                     rf_wr, wb_sel, alu_src, alu_op, flag_wr} == '0)
                else $error("strobe active during reset");
        end
    end

    p_fetch_follows_r2: assert property (@(posedge clk) disable iff (rst)
        pc_rd |=> (ir_rd && !pc_rd));

    p_one_phase_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_rd, ir_rd, dm_rd, dm_wr, rf_wr, flag_wr}));

    p_ld_writeback_r5: assert property (@(posedge clk) disable iff (rst)
        dm_rd |=> (rf_wr && wb_sel && pc_wr && !pc_sel));

    p_store_final_r6: assert property (@(posedge clk) disable iff (rst)
        dm_wr |-> (pc_wr && !pc_sel && !rf_wr));

    p_cmp_no_rf_r7: assert property (@(posedge clk) disable iff (rst)
        flag_wr |-> (!rf_wr && pc_wr && alu_op == 2'b11));

    p_sel_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
        pc_sel |-> pc_wr);

    p_pcwr_ends_r11: assert property (@(posedge clk) disable iff (rst)
        pc_wr |=> pc_rd);

endmodule

bind mc_ctrl mc_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_rd   (pc_rd),
    .pc_wr   (pc_wr),
    .pc_sel  (pc_sel),
    .ir_rd   (ir_rd),
    .dm_rd   (dm_rd),
    .dm_wr   (dm_wr),
    .rf_wr   (rf_wr),
    .wb_sel  (wb_sel),
    .alu_src (alu_src),
    .alu_op  (alu_op),
    .flag_wr (flag_wr)
);

// File: tb/mc_ctrl_bench.sv
module mc_ctrl_bench;

    localparam logic [11:0] B_PCRD  = 12'h800;
    localparam logic [11:0] B_PCWR  = 12'h400;
    localparam logic [11:0] B_PCSEL = 12'h200;
    localparam logic [11:0] B_IRRD  = 12'h100;
    localparam logic [11:0] B_DMRD  = 12'h080;
    localparam logic [11:0] B_DMWR  = 12'h040;
    localparam logic [11:0] B_RFWR  = 12'h020;
    localparam logic [11:0] B_WBSEL = 12'h010;
    localparam logic [11:0] B_ASRC  = 12'h008;
    localparam logic [11:0] B_FLAG  = 12'h001;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] opcode;
    logic       br_taken;
    logic       pc_rd, pc_wr, pc_sel, ir_rd, dm_rd, dm_wr, rf_wr, wb_sel, alu_src, flag_wr;
    logic [1:0] alu_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    mc_ctrl u_mc_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .br_taken (br_taken),
        .pc_rd    (pc_rd),
        .pc_wr    (pc_wr),
        .pc_sel   (pc_sel),
        .ir_rd    (ir_rd),
        .dm_rd    (dm_rd),
        .dm_wr    (dm_wr),
        .rf_wr    (rf_wr),
        .wb_sel   (wb_sel),
        .alu_src  (alu_src),
        .alu_op   (alu_op),
        .flag_wr  (flag_wr)
    );

    wire [11:0] got = {pc_rd, pc_wr, pc_sel, ir_rd, dm_rd, dm_wr,
                       rf_wr, wb_sel, alu_src, alu_op, flag_wr};

    task automatic push(input logic [11:0] e, input string tag);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // monitor: one expected vector per cycle, sampled 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [11:0] e;
            string       t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s: strobes got %03h expected %03h (opcode %0d br %0b)",
                         t, got, e, opcode, br_taken);
            end
        end
    end

    // driver: called on a falling edge in the PC-read cycle of a new instruction
    task automatic run(input logic [3:0] op, input logic br, input string tag);
        int n0;
        n0 = q_exp.size();
        push(B_PCRD, "R2 R11");
        push(B_IRRD, "R2");
        case (op)
            4'd0, 4'd1: begin
                push({9'd0, (op == 4'd1 ? 2'b01 : 2'b00), 1'b0}, tag);
                push(B_RFWR | B_PCWR, tag);
            end
            4'd2, 4'd3: begin
                push(B_ASRC | {9'd0, (op == 4'd3 ? 2'b01 : 2'b00), 1'b0}, tag);
                push(B_RFWR | B_PCWR, tag);
            end
            4'd4: begin
                push(B_DMRD, tag);
                push(B_RFWR | B_WBSEL | B_PCWR, tag);
            end
            4'd5: push(B_DMWR | B_PCWR, tag);
            4'd6: push(12'h006 | B_FLAG | B_PCWR, tag);
            4'd7: push(B_PCWR | B_PCSEL, tag);
            4'd8, 4'd9, 4'd10, 4'd11, 4'd12:
                  push(B_PCWR | (br ? B_PCSEL : 12'h000), tag);
            default: push(B_PCWR, tag);
        endcase
        opcode   = op;
        br_taken = br;
        repeat (q_exp.size() - n0) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        rst      = 1'b1;
        opcode   = 4'd4;
        br_taken = 1'b1;
        @(negedge clk);
        push(12'h000, "R1");
        @(negedge clk);
        push(12'h000, "R1");
        @(negedge clk);
        rst = 1'b0;

        run(4'd0, 1'b0, "R3");
        run(4'd0, 1'b1, "R3");
        run(4'd1, 1'b1, "R3");
        run(4'd2, 1'b0, "R4");
        run(4'd3, 1'b1, "R4");
        run(4'd4, 1'b0, "R5");
        run(4'd4, 1'b1, "R5");
        run(4'd5, 1'b0, "R6");
        run(4'd5, 1'b1, "R6");
        run(4'd6, 1'b1, "R7");
        run(4'd7, 1'b0, "R8");
        run(4'd7, 1'b1, "R8");
        for (int k = 8; k <= 12; k++) begin
            run(4'(k), 1'b0, "R9");
            run(4'(k), 1'b1, "R9");
        end
        for (int k = 13; k <= 15; k++) begin
            run(4'(k), 1'b1, "R10");
        end

        // reset in the middle of a load: strobes drop, fetch restarts
        push(B_PCRD, "R2");
        push(B_IRRD, "R2");
        push(12'h000, "R1");
        opcode = 4'd4;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run(4'd5, 1'b0, "R1 R6");

        // back-to-back mix to check instruction boundaries
        run(4'd6, 1'b0, "R7");
        run(4'd8, 1'b1, "R9");
        run(4'd2, 1'b1, "R4");
        run(4'd11, 1'b0, "R9");
        run(4'd1, 1'b0, "R3");
        push(B_PCRD, "R11");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got %03h expected completion", got);
            summary();
            $finish;
        end
    end

endmodule